// File: doc/BRIEF.md
# Deep-Sleep Power Mode Sequencer

This block drives the power-down request of an asynchronous memory that has an active-low sleep input. It samples the sleep request and the memory's active-low chip enable on every clock edge. From these it keeps a small state machine with four states: active, settling into sleep, fully asleep, and waiting after release. The block's outputs tell the surrounding access logic when a read or write may be issued, when the data pins must be released, and when a recovery rule was broken.

The block counts how many consecutive clock edges see the sleep request held low. If the request is released before the minimum low time has been reached, the memory never really entered sleep, and access is allowed again at once. If the minimum was reached, the block holds off all access for a fixed recovery period. During the first part of that period the chip must also be deselected. If chip enable is still asserted when that window closes, a sticky data-loss flag is raised.

Every duration is given as a time in nanoseconds and turned into a whole number of clock cycles. An integer clock-period parameter is used for that conversion.

Top module: `dsleep_seq`

## Requirements
- R1: After reset the block is in the active state with `data_loss`=0 and `busy`=0, and `access_ok`=1 while `sleep_n`=1.
- R2: In any cycle where `sleep_n`=0, `access_ok`=0 and `force_hiz`=1 in that same cycle, before any clock edge. This cuts off a write in progress.
- R3: While `sleep_n` is held low, `busy`=1 until SETTLE_CYC consecutive low samples have been taken. From then on `busy`=0, and `force_hiz` stays 1 for as long as the request is low.
- R4: If `sleep_n` is released after fewer than MIN_CYC consecutive low samples, `access_ok`=1 in the cycle after the release edge, with no recovery wait. No chip-enable check is made.
- R5: If `sleep_n` is released after at least MIN_CYC low samples, `access_ok`=0 and `busy`=1 for exactly EXIT_CYC cycles after the release edge. `force_hiz`=0 during that wait, and `access_ok` returns to 1 afterwards.
- R6: If `ce_n`=0 at the edge that closes the chip-enable window, `data_loss` becomes 1 and stays 1 until reset. That edge is the CEWIN_CYC-th edge after the release edge.
- R7: If `ce_n`=1 at the edge that closes the window, `data_loss` stays 0. This holds even if `ce_n` was low earlier in the window.
- R8: While the block is asleep, `ce_n` has no effect on any output.
- R9: A new sleep request seen in the last cycle of the recovery wait wins over the return to active. The block goes back to settling, and the minimum-low rule applies again.
- R10: Each cycle count is the ceiling of its time parameter divided by CLK_PERIOD_NS. MIN_CYC is at least 1, SETTLE_CYC is at least the larger of MIN_CYC and 2, and CEWIN_CYC is at most EXIT_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_n | input | 1 | Sleep request, low asks for deep sleep (synchronous to clk) |
| ce_n | input | 1 | Memory chip enable, low selects the chip |
| access_ok | output | 1 | A read or write may be issued this cycle |
| busy | output | 1 | Settling into sleep or waiting after release |
| force_hiz | output | 1 | Memory data pins must be treated as high impedance |
| data_loss | output | 1 | Sticky flag: chip enable still asserted when the window closed |

## Verification
Two events can fall on the same edge: the recovery wait expiring and a fresh sleep request. To provoke this, the bench lowers `sleep_n` just before the EXIT_CYC-th edge after a release. It then expects `busy` and `force_hiz` high with access still blocked, instead of a return to active. The bench then releases again after exactly MIN_CYC low samples and expects a second full recovery wait. The minimum-low boundary itself is swept for every low length from 1 up past SETTLE_CYC. At each length the bench computes whether a wait is due, and how long it lasts, from the nanosecond parameters.

// File: rtl/dsleep_pkg.sv
// Package: shared state encoding and the time-to-cycle conversion for the
// deep-sleep sequencer. Assumes all times are whole nanoseconds.
package dsleep_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_EXIT   = 2'd3
    } dsleep_state_t;

    // Ceiling division of a time in ns by the clock period in ns (R10)
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dsleep_low_timer.sv
// Module: counts consecutive clock edges on which the sleep request is low.
// A start loads 1 (the first low sample); run adds one and saturates at
// SETTLE_CYC. Assumes MIN_CYC <= SETTLE_CYC and SETTLE_CYC >= 2.
module dsleep_low_timer #(
    parameter int MIN_CYC    = 5,
    parameter int SETTLE_CYC = 20,
    parameter int W          = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic min_met,
    output logic settle_next
);
    localparam logic [W-1:0] SAT     = W'(SETTLE_CYC);
    localparam logic [W-1:0] MIN_V   = W'(MIN_CYC);
    localparam logic [W-1:0] LAST_V  = W'(SETTLE_CYC - 1);

    logic [W-1:0] cnt;

    // Low-sample counter: load on a new request, saturate while held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(1);
        end else if (run && cnt != SAT) begin
            cnt <= cnt + W'(1);
        end
    end

    // Threshold decode for the state machine
    always_comb begin
        min_met     = (cnt >= MIN_V);
        settle_next = (cnt >= LAST_V);
    end

endmodule

// File: rtl/dsleep_exit_timer.sv
// Module: counts cycles of the post-release recovery wait. A start loads 0
// on the release edge; run advances it while the wait continues. Flags the
// last wait cycle and the cycle that closes the chip-enable window.
// Assumes 1 <= CEWIN_CYC <= EXIT_CYC.
module dsleep_exit_timer #(
    parameter int EXIT_CYC  = 30,
    parameter int CEWIN_CYC = 10,
    parameter int W         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic last,
    output logic window_end
);
    localparam logic [W-1:0] LAST_V = W'(EXIT_CYC - 1);
    localparam logic [W-1:0] WIN_V  = W'(CEWIN_CYC - 1);

    logic [W-1:0] cnt;

    // Recovery counter: cleared at release, stops at its last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && cnt != LAST_V) begin
            cnt <= cnt + W'(1);
        end
    end

    // Decode of the two deadlines
    always_comb begin
        last       = (cnt == LAST_V);
        window_end = (cnt == WIN_V);
    end

endmodule

// File: rtl/dsleep_fsm.sv
// Module: four-state power sequencer. Decides entry into settling, full
// sleep, the recovery wait and the return to active from the sleep request
// and the two timers. Also issues the timer controls. Assumes sleep_n is
// already synchronous to clk.
module dsleep_fsm
    import dsleep_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_n,
    input  logic          min_met,
    input  logic          settle_next,
    input  logic          exit_last,
    output dsleep_state_t state,
    output logic          low_start,
    output logic          low_run,
    output logic          exit_start,
    output logic          exit_run
);
    dsleep_state_t state_nx;

    // Next-state selection; a new request in the wait wins over expiry (R9)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE: if (!sleep_n) state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (sleep_n)          state_nx = min_met ? ST_EXIT : ST_ACTIVE;
                else if (settle_next) state_nx = ST_ASLEEP;
            end
            ST_ASLEEP: if (sleep_n) state_nx = ST_EXIT;
            ST_EXIT: begin
                if (!sleep_n)       state_nx = ST_SETTLE;
                else if (exit_last) state_nx = ST_ACTIVE;
            end
            default: state_nx = ST_ACTIVE;
        endcase
    end

    // Timer controls derived from the current state and request
    always_comb begin
        low_start  = (state == ST_ACTIVE || state == ST_EXIT) && !sleep_n;
        low_run    = (state == ST_SETTLE || state == ST_ASLEEP) && !sleep_n;
        exit_start = sleep_n && ((state == ST_SETTLE && min_met) || state == ST_ASLEEP);
        exit_run   = (state == ST_EXIT) && sleep_n;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nx;
    end

    AST_SHORT_PULSE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && sleep_n && !min_met) |=> (state == ST_ACTIVE)); // R4
    AST_LONG_LOW_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && sleep_n && min_met) |=> (state == ST_EXIT)); // R5
    AST_EXIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT && sleep_n && !exit_last) |=> (state == ST_EXIT)); // R5
    AST_RESLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT && !sleep_n) |=> (state == ST_SETTLE)); // R9

endmodule

// File: rtl/dsleep_loss_flag.sv
// Module: sticky data-loss indicator. Sets when the chip-enable window of
// the recovery wait closes with the chip still selected; clears only on
// reset.
module dsleep_loss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic in_exit,
    input  logic window_end,
    input  logic ce_n,
    output logic data_loss
);
    // Sticky set on a missed deselect
    always_ff @(posedge clk) begin
        if (!rst_n)                           data_loss <= 1'b0;
        else if (in_exit && window_end && !ce_n) data_loss <= 1'b1;
    end

    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        data_loss |=> data_loss); // R6
    AST_LOSS_NEEDS_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_loss) |-> !$past(ce_n)); // R7

endmodule

// File: rtl/dsleep_seq.sv
// Module: top of the deep-sleep sequencer. Converts the nanosecond timing
// parameters into cycle counts (R10), joins the timers, the state machine
// and the loss flag, and forms the status outputs. Assumes sleep_n and ce_n
// are synchronous to clk.
module dsleep_seq
    import dsleep_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int MIN_LOW_NS    = 100,
    parameter int SETTLE_NS     = 1000000,
    parameter int EXIT_WAIT_NS  = 300000,
    parameter int CE_WINDOW_NS  = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    input  logic ce_n,
    output logic access_ok,
    output logic busy,
    output logic force_hiz,
    output logic data_loss
);
    // R10: ceiling conversion with the ordering clamps
    localparam int MIN_CYC    = max_int(1, ns_to_cycles(MIN_LOW_NS, CLK_PERIOD_NS));
    localparam int SETTLE_CYC = max_int(max_int(2, MIN_CYC),
                                        ns_to_cycles(SETTLE_NS, CLK_PERIOD_NS));
    localparam int EXIT_CYC   = max_int(1, ns_to_cycles(EXIT_WAIT_NS, CLK_PERIOD_NS));
    localparam int CEWIN_CYC  = min_int(EXIT_CYC,
                                        max_int(1, ns_to_cycles(CE_WINDOW_NS, CLK_PERIOD_NS)));
    localparam int LOW_W      = $clog2(SETTLE_CYC + 1);
    localparam int EXIT_W     = $clog2(EXIT_CYC + 1);

    dsleep_state_t state;
    logic low_start, low_run, exit_start, exit_run;
    logic min_met, settle_next, exit_last, window_end;

    dsleep_low_timer #(
        .MIN_CYC    (MIN_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .W          (LOW_W)
    ) i_low_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (low_start),
        .run         (low_run),
        .min_met     (min_met),
        .settle_next (settle_next)
    );

    dsleep_exit_timer #(
        .EXIT_CYC  (EXIT_CYC),
        .CEWIN_CYC (CEWIN_CYC),
        .W         (EXIT_W)
    ) i_exit_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (exit_start),
        .run        (exit_run),
        .last       (exit_last),
        .window_end (window_end)
    );

    dsleep_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_n     (sleep_n),
        .min_met     (min_met),
        .settle_next (settle_next),
        .exit_last   (exit_last),
        .state       (state),
        .low_start   (low_start),
        .low_run     (low_run),
        .exit_start  (exit_start),
        .exit_run    (exit_run)
    );

    dsleep_loss_flag i_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_exit    (state == ST_EXIT),
        .window_end (window_end),
        .ce_n       (ce_n),
        .data_loss  (data_loss)
    );

    // Status outputs; a low request blocks access in the same cycle (R2)
    always_comb begin
        access_ok = (state == ST_ACTIVE) && sleep_n;
        busy      = (state == ST_SETTLE) || (state == ST_EXIT);
        force_hiz = !sleep_n || (state == ST_SETTLE) || (state == ST_ASLEEP);
    end

    AST_SLEEP_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |-> (!access_ok && force_hiz)); // R2
    AST_ASLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ASLEEP) |-> (force_hiz && !busy && !access_ok)); // R3
    AST_WAIT_NO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT && sleep_n) |-> (!force_hiz && !access_ok)); // R5

endmodule

// File: tb/test_dsleep_seq.sv
module test_dsleep_seq;
    localparam int P_NS = 20;
    localparam int MIN_NS = 90, SET_NS = 400, EXIT_NS = 600, WIN_NS = 190;
    // R10: expected cycles by ceiling division, computed here
    localparam int MIN_C  = (MIN_NS + P_NS - 1) / P_NS;   // 5
    localparam int SET_C  = (SET_NS + P_NS - 1) / P_NS;   // 20
    localparam int EXIT_C = (EXIT_NS + P_NS - 1) / P_NS;  // 30
    localparam int WIN_C  = (WIN_NS + P_NS - 1) / P_NS;   // 10

    logic clk = 1'b0, rst_n = 1'b0, sleep_n = 1'b1, ce_n = 1'b1;
    logic access_ok, busy, force_hiz, data_loss;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dsleep_seq #(
        .CLK_PERIOD_NS (P_NS),
        .MIN_LOW_NS    (MIN_NS),
        .SETTLE_NS     (SET_NS),
        .EXIT_WAIT_NS  (EXIT_NS),
        .CE_WINDOW_NS  (WIN_NS)
    ) i_dsleep_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n   (sleep_n),
        .ce_n      (ce_n),
        .access_ok (access_ok),
        .busy      (busy),
        .force_hiz (force_hiz),
        .data_loss (data_loss)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_n = 1'b1; ce_n = 1'b1;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
    endtask

    // Hold sleep low for len samples, then release; returns at negedge after release edge
    task automatic low_then_release(input int len);
        sleep_n = 1'b0;
        cycles(len);
        sleep_n = 1'b1;
        cycles(1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "access_ok", access_ok, 1'b1);
        check("R1", "busy", busy, 1'b0);
        check("R1", "force_hiz", force_hiz, 1'b0);
        check("R1", "data_loss", data_loss, 1'b0);

        // Sweep of low lengths across the minimum and settle boundaries
        for (int len = 1; len <= SET_C + 5; len++) begin
            sleep_n = 1'b0;
            #1;
            check("R2", "access_ok same cycle", access_ok, 1'b0);
            check("R2", "force_hiz same cycle", force_hiz, 1'b1);
            cycles(len);
            check("R3", "busy while low", busy, (len < SET_C) ? 1'b1 : 1'b0);
            check("R3", "force_hiz while low", force_hiz, 1'b1);
            sleep_n = 1'b1;
            cycles(1);
            if (len >= MIN_C) begin
                check("R5", "access blocked at release", access_ok, 1'b0);
                check("R5", "busy at release", busy, 1'b1);
                check("R5", "no hiz in wait", force_hiz, 1'b0);
                cycles(EXIT_C - 1);
                check("R5", "access blocked last wait cycle", access_ok, 1'b0);
                cycles(1);
                check("R5", "access after wait", access_ok, 1'b1);
            end else begin
                check("R4", "access right after short pulse", access_ok, 1'b1);
                check("R4", "no busy after short pulse", busy, 1'b0);
            end
            check("R7", "no loss with ce high", data_loss, 1'b0);
        end

        // R4: short pulse with chip selected makes no loss check
        ce_n = 1'b0;
        low_then_release(MIN_C - 1);
        cycles(WIN_C + 2);
        check("R4", "loss after short pulse", data_loss, 1'b0);
        ce_n = 1'b1;

        // R8: chip enable toggling while asleep changes nothing
        sleep_n = 1'b0;
        cycles(SET_C + 1);
        for (int i = 0; i < 6; i++) begin
            ce_n = ~ce_n;
            cycles(1);
            check("R8", "busy asleep", busy, 1'b0);
            check("R8", "hiz asleep", force_hiz, 1'b1);
            check("R8", "access asleep", access_ok, 1'b0);
        end
        ce_n = 1'b1;
        sleep_n = 1'b1;
        cycles(EXIT_C + 1);
        check("R8", "loss after asleep toggles", data_loss, 1'b0);

        // R7: chip selected early in the window, deselected before it closes
        ce_n = 1'b0;
        low_then_release(SET_C + 2);
        cycles(WIN_C - 5);
        ce_n = 1'b1;
        cycles(6);
        check("R7", "no loss when deselected in time", data_loss, 1'b0);
        cycles(EXIT_C);

        // R6: chip still selected at window close
        ce_n = 1'b0;
        low_then_release(SET_C + 2);
        cycles(WIN_C - 1);
        check("R6", "loss before window close", data_loss, 1'b0);
        cycles(1);
        check("R6", "loss at window close", data_loss, 1'b1);
        ce_n = 1'b1;
        cycles(EXIT_C);
        check("R6", "loss sticky", data_loss, 1'b1);
        do_reset();
        check("R6", "loss cleared by reset", data_loss, 1'b0);

        // R9: new request in the last wait cycle wins
        low_then_release(SET_C + 2);
        cycles(EXIT_C - 1);
        sleep_n = 1'b0;
        cycles(1);
        check("R9", "busy after re-request", busy, 1'b1);
        check("R9", "hiz after re-request", force_hiz, 1'b1);
        check("R9", "access blocked after re-request", access_ok, 1'b0);
        cycles(MIN_C - 1);
        sleep_n = 1'b1;
        cycles(1);
        check("R9", "min met again gives wait", busy, 1'b1);
        check("R10", "wait length uses ceiling", access_ok, 1'b0);
        cycles(EXIT_C - 1);
        check("R10", "still blocked at ceil-1", access_ok, 1'b0);
        cycles(1);
        check("R10", "access at ceil count", access_ok, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule